// File: doc/BRIEF.md
# Coprocessor Control and Software Trigger Registers

This block holds the host-visible control state of a co-processor. It sits on a simple word-addressed register bus and exposes two 16-bit registers: a control register and a software trigger register. In both, the upper byte carries per-bit write enables and the lower byte carries the data. A host can therefore set or clear any single control bit in one write, without reading the register first, and without disturbing the other bits.

The control register drives the module-enable, halt-in-freeze, debug, single-step, fake-activity and global interrupt enable outputs. It also holds a software-error flag, which the engine raises with a one-cycle pulse and the host clears. The block gates every co-processor interrupt output with the global interrupt enable. It also forms the activity indication from the engine's busy signal and the fake-activity bit. The eight software trigger bits leave the block as request lines for eight software channels.

Top module: `cpctl_regs`

## Requirements
- R1: After reset every data bit in both registers is 0. Both registers read back as 0x0000, and every control, request and interrupt output is 0.
- R2: A write to the control register (word address CTRL_ADDR, default 0) updates data bit n only for n in {7 enable, 6 halt-in-freeze, 5 debug, 4 single step, 3 fake activity, 0 interrupt enable}, and only when mask bit n+8 of the same write is 1. Bits whose mask is 0 hold their value.
- R3: A register changes only on a clock edge where we_i is 1 and addr_i matches its word address. A write to an unmapped address, or bus activity with we_i at 0, leaves both registers unchanged.
- R4: Mask bits 15:8 of both registers always read as 0. Reserved data bit 2 of the control register always reads 0, and writes to it and to its mask bit 10 have no effect. Unmapped addresses read 0x0000.
- R5: activity_o is 1 when busy_i is 1 or the fake-activity bit (control bit 3) is 1, and 0 otherwise.
- R6: When control bit 0 is 0, chan_irq_o and sw_err_irq_o are 0. When it is 1, chan_irq_o equals chan_irq_i and sw_err_irq_o equals the software-error flag.
- R7: A pulse on sw_err_set_i sets the software-error flag (control bit 1) at the next edge. A control write with data bit 1 and mask bit 9 both 1 clears it. A write of bit 1 without mask bit 9, or with data bit 1 at 0, leaves it unchanged. A set pulse and a clearing write on the same edge leave the flag set.
- R8: A write to the trigger register (word address TRIG_ADDR, default 1) updates trigger bit n (0..7) from data bit n only when mask bit n+8 is 1. Bit n drives sw_req_o[n].
- R9: Trigger bits change only through trigger register writes. Control writes and error pulses do not affect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data, masks in 15:8 and data in 7:0 |
| rdata_o | output | 16 | Read data for addr_i |
| busy_i | input | 1 | Engine is not idle |
| sw_err_set_i | input | 1 | Software-error pulse from the engine |
| chan_irq_i | input | N_CHAN | Raw channel interrupts |
| enable_o | output | 1 | Module enable |
| frz_halt_o | output | 1 | Halt in freeze |
| dbg_o | output | 1 | Debug mode |
| sstep_o | output | 1 | Single step |
| fake_act_o | output | 1 | Fake activity |
| irq_en_o | output | 1 | Global interrupt enable |
| sw_err_o | output | 1 | Software-error flag |
| activity_o | output | 1 | Activity indication |
| chan_irq_o | output | N_CHAN | Gated channel interrupts |
| sw_err_irq_o | output | 1 | Gated software-error interrupt |
| sw_req_o | output | 8 | Software channel requests |

## Verification
The bench builds the block with the default ADDR_W of 4, N_CHAN of 4, CTRL_ADDR of 0 and TRIG_ADDR of 1. This leaves address 2 unmapped, so writes that miss both registers can be tried. With four channel interrupt lines, all-ones and all-zeros gating patterns can be checked in full. The mask layout is fixed at 16 bits, so every mask/data combination that matters is reachable by walking single and grouped mask bits.

// File: rtl/cpctl_pkg.sv
package cpctl_pkg;
  localparam int BUS_W  = 16;
  localparam int HALF_W = BUS_W / 2;

  // control data bit positions (low byte); mask is at position + HALF_W
  localparam int B_EN   = 7;
  localparam int B_FRZ  = 6;
  localparam int B_DBG  = 5;
  localparam int B_SS   = 4;
  localparam int B_FAKE = 3;
  localparam int B_ERR  = 1;
  localparam int B_IE   = 0;

  // bits held as plain masked flops in the control register
  localparam logic [HALF_W-1:0] CTRL_FLOPS = (HALF_W'(1) << B_EN)  | (HALF_W'(1) << B_FRZ) |
                                             (HALF_W'(1) << B_DBG) | (HALF_W'(1) << B_SS)  |
                                             (HALF_W'(1) << B_FAKE)| (HALF_W'(1) << B_IE);
  localparam logic [HALF_W-1:0] TRIG_FLOPS = '1;
endpackage

// File: rtl/cpctl_mask_reg.sv
module cpctl_mask_reg #(
  parameter int                W       = 8,
  parameter logic [W-1:0]      FLOPS   = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FLOPS[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                q <= 1'b0;
        else if (wr_i && mask_i[i]) q <= data_i[i];
      end
      assign q_o[i] = q;

      a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && mask_i[i]) |=> $stable(q_o[i]));
      a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && mask_i[i]) |=> (q_o[i] == $past(data_i[i])));
    end else begin : g_rsv
      logic unused_rsv;
      assign unused_rsv = mask_i[i] ^ data_i[i];
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cpctl_err_flag.sv
module cpctl_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set wins so an engine event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end
  assign flag_o = flag_q;

  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_o));
  a_r7_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && clr_i) |=> !flag_o);
endmodule

// File: rtl/cpctl_regs.sv
module cpctl_regs
  import cpctl_pkg::*;
#(
  parameter int               ADDR_W    = 4,
  parameter int               N_CHAN    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 0,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              sw_err_set_i,
  input  logic [N_CHAN-1:0] chan_irq_i,
  output logic              enable_o,
  output logic              frz_halt_o,
  output logic              dbg_o,
  output logic              sstep_o,
  output logic              fake_act_o,
  output logic              irq_en_o,
  output logic              sw_err_o,
  output logic              activity_o,
  output logic [N_CHAN-1:0] chan_irq_o,
  output logic              sw_err_irq_o,
  output logic [HALF_W-1:0] sw_req_o
);
  logic              ctrl_wr, trig_wr;
  logic [HALF_W-1:0] wmask, wdat;
  logic [HALF_W-1:0] ctrl_q, trig_q, ctrl_rd;
  logic              err_q;

  assign wmask   = wdata_i[BUS_W-1:HALF_W];
  assign wdat    = wdata_i[HALF_W-1:0];
  assign ctrl_wr = we_i && (addr_i == CTRL_ADDR);
  assign trig_wr = we_i && (addr_i == TRIG_ADDR);

  cpctl_mask_reg #(.W(HALF_W), .FLOPS(CTRL_FLOPS)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(ctrl_wr), .mask_i(wmask), .data_i(wdat), .q_o(ctrl_q)
  );

  cpctl_mask_reg #(.W(HALF_W), .FLOPS(TRIG_FLOPS)) u_trig (
    .clk_i, .rst_ni, .wr_i(trig_wr), .mask_i(wmask), .data_i(wdat), .q_o(trig_q)
  );

  cpctl_err_flag u_err (
    .clk_i, .rst_ni,
    .set_i (sw_err_set_i),
    .clr_i (ctrl_wr && wmask[B_ERR] && wdat[B_ERR]),
    .flag_o(err_q)
  );

  always_comb begin
    ctrl_rd        = ctrl_q;
    ctrl_rd[B_ERR] = err_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR)      rdata_o[HALF_W-1:0] = ctrl_rd;
    else if (addr_i == TRIG_ADDR) rdata_o[HALF_W-1:0] = trig_q;
  end

  assign enable_o     = ctrl_q[B_EN];
  assign frz_halt_o   = ctrl_q[B_FRZ];
  assign dbg_o        = ctrl_q[B_DBG];
  assign sstep_o      = ctrl_q[B_SS];
  assign fake_act_o   = ctrl_q[B_FAKE];
  assign irq_en_o     = ctrl_q[B_IE];
  assign sw_err_o     = err_q;
  assign activity_o   = busy_i || ctrl_q[B_FAKE];
  assign chan_irq_o   = ctrl_q[B_IE] ? chan_irq_i : '0;
  assign sw_err_irq_o = ctrl_q[B_IE] && err_q;
  assign sw_req_o     = trig_q;

  a_r6_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_o |-> (chan_irq_o == '0 && !sw_err_irq_o));
  a_r5_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> activity_o);
  a_r9_trig_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_wr |=> $stable(sw_req_o));
  a_r3_ctrl_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> ($stable(enable_o) && $stable(irq_en_o) && $stable(dbg_o)));
endmodule

// File: tb/tb_cpctl_regs.sv
module tb_cpctl_regs;
  localparam int ADDR_W = 4;
  localparam int N_CHAN = 4;
  localparam int NV     = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;
  logic              busy = 1'b0, err_set = 1'b0;
  logic [N_CHAN-1:0] cirq_i = '0, cirq_o;
  logic              en, frz, dbg, ss, fake, ie, err, act, err_irq;
  logic [7:0]        req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cpctl_regs #(.ADDR_W(ADDR_W), .N_CHAN(N_CHAN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .busy_i(busy), .sw_err_set_i(err_set), .chan_irq_i(cirq_i),
    .enable_o(en), .frz_halt_o(frz), .dbg_o(dbg), .sstep_o(ss), .fake_act_o(fake),
    .irq_en_o(ie), .sw_err_o(err), .activity_o(act), .chan_irq_o(cirq_o),
    .sw_err_irq_o(err_irq), .sw_req_o(req)
  );

  // row: {is_trig, wdata, expected readback}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h8080, 16'h0080},
    {1'b0, 16'h0040, 16'h0080},
    {1'b0, 16'h7F7F, 16'h00F9},
    {1'b0, 16'h8000, 16'h0079},
    {1'b0, 16'h2400, 16'h0059},
    {1'b0, 16'hFF00, 16'h0000},
    {1'b0, 16'h1114, 16'h0010},
    {1'b1, 16'hFFA5, 16'h00A5},
    {1'b1, 16'h0F00, 16'h00A0},
    {1'b1, 16'h005A, 16'h00A0},
    {1'b1, 16'h3030, 16'h00B0},
    {1'b1, 16'h8000, 16'h0030}
  };

  task automatic chk(input string req_s, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_s, a, e);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic strobe);
    @(negedge clk);
    addr = a; wdata = d; we = strobe;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [7:0] ctrl_outs();
    return {en, frz, dbg, ss, fake, 1'b0, err, ie};
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, r); chk("R1 ctrl rd", 32'(r), 32'h0);
    rd(1, r); chk("R1 trig rd", 32'(r), 32'h0);
    chk("R1 outs", {ctrl_outs(), req, act, err_irq}, 32'h0);

    // R2 R4 R8 table walk
    for (int i = 0; i < NV; i++) begin
      logic [ADDR_W-1:0] a;
      a = VEC[i][32] ? ADDR_W'(1) : ADDR_W'(0);
      wr(a, VEC[i][31:16], 1'b1);
      rd(a, r);
      chk(VEC[i][32] ? "R8 trig rd" : "R2 R4 ctrl rd", 32'(r), 32'(VEC[i][15:0]));
      if (VEC[i][32]) chk("R8 sw_req", 32'(req), 32'(VEC[i][7:0]));
      else            chk("R2 ctrl outs", 32'(ctrl_outs()), 32'(VEC[i][7:0]));
    end

    // R3 unmapped address and no strobe
    wr(2, 16'hFFFF, 1'b1);
    rd(2, r); chk("R4 unmapped rd", 32'(r), 32'h0);
    rd(0, r); chk("R3 ctrl after unmapped", 32'(r), 32'h0010);
    rd(1, r); chk("R3 trig after unmapped", 32'(r), 32'h0030);
    wr(0, 16'hFFFF, 1'b0);
    rd(0, r); chk("R3 ctrl no strobe", 32'(r), 32'h0010);
    wr(1, 16'hFF00, 1'b0);
    rd(1, r); chk("R3 trig no strobe", 32'(r), 32'h0030);

    // R5 activity
    busy = 1'b0; #1; chk("R5 idle", 32'(act), 32'h0);
    busy = 1'b1; #1; chk("R5 busy", 32'(act), 32'h1);
    busy = 1'b0;
    wr(0, 16'h0808, 1'b1);
    #1; chk("R5 fake idle", 32'(act), 32'h1);

    // R6 interrupt gating
    cirq_i = 4'hF; #1;
    chk("R6 gated off", 32'(cirq_o), 32'h0);
    wr(0, 16'h0101, 1'b1);
    #1; chk("R6 gated on", 32'(cirq_o), 32'hF);
    cirq_i = 4'h5; #1; chk("R6 pattern", 32'(cirq_o), 32'h5);

    // R7 software error flag
    @(negedge clk); err_set = 1'b1;
    @(negedge clk); err_set = 1'b0;
    chk("R7 set", 32'(err), 32'h1);
    chk("R6 err irq", 32'(err_irq), 32'h1);
    rd(0, r); chk("R7 rd bit1", 32'(r), 32'h001B);
    rd(1, r); chk("R9 trig after pulse", 32'(r), 32'h0030);
    wr(0, 16'h0002, 1'b1); chk("R7 no mask", 32'(err), 32'h1);
    wr(0, 16'h0200, 1'b1); chk("R7 mask data0", 32'(err), 32'h1);
    wr(0, 16'h0202, 1'b1); chk("R7 clear", 32'(err), 32'h0);
    @(negedge clk);
    addr = 0; wdata = 16'h0202; we = 1'b1; err_set = 1'b1;
    @(negedge clk);
    we = 1'b0; err_set = 1'b0;
    chk("R7 set wins", 32'(err), 32'h1);
    wr(0, 16'h0100, 1'b1);
    #1; chk("R6 err irq off", {31'(cirq_o), err_irq}, 32'h0);

    // R9 control writes leave triggers alone
    wr(0, 16'hFFFF, 1'b1);
    rd(1, r); chk("R9 trig after ctrl", 32'(r), 32'h0030);
    chk("R9 sw_req", 32'(req), 32'h30);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule